// File: doc/BRIEF.md
# Dead Link Watchdog for a Four-Port Group

This block decides when a serial link partner has gone silent for good. It watches the lane synchronization status of four ports that share one instance; on a switch these ports sit at positions N, N+1, N+8 and N+9 for a group base N of 0, 2, 4 or 6. The ports share a prescaler that produces a slow tick. While a port's lane synchronization is lost, its own counter advances on each tick. If the count reaches the programmed threshold, the port is declared dead. A global enable can turn the whole function off.

When a port is declared dead, several things happen at once. A sticky error status bit is set. A one-cycle notification request is raised if notifications are enabled for that port. The transmit buffer is told to flush. The port then enters a discard state. In that state, packets offered by the switch fabric are still handshaked as accepted but never reach the transmitter, so fabric traffic keeps moving. Traffic received from the partner continues to flow to the fabric unchanged. The discard state ends when the link trains up again.

The block carries only the valid/ready handshakes. Packet data is routed around it.

Top module: `dlink_guard`

## Requirements
- R1: After synchronous reset, `port_err`, `discard`, `notify_req` and `txbuf_flush` are all 0.
- R2: While `cfg_enable` is 0, no port expires. The lost-sync count of every port is held at zero, so counting starts afresh once the enable returns.
- R3: A tick occurs on every PRESCALE-th clock edge counted from reset. With the enable at 1, lane sync lost and the port not discarding, the port's count advances on each tick. The port expires on the tick that brings the count to T, where T is `cfg_thresh` and a value of 0 counts as 1. At that edge `port_err[i]` and `discard[i]` both rise.
- R4: A single cycle with `lane_sync[i]` at 1 before expiry returns the port's count to zero.
- R5: `port_err[i]` stays at 1 until a cycle in which `err_clr[i]` is 1. If an expiry falls in that same cycle, the bit stays set.
- R6: `notify_req[i]` is a one-cycle pulse. It is raised on the edge where `port_err[i]` goes from 0 to 1, and only if `notify_en[i]` is 1 in that cycle.
- R7: `txbuf_flush[i]` is a one-cycle pulse on the edge where `discard[i]` rises.
- R8: While `discard[i]` is 1, `eg_ready[i]` is 1 and `tx_valid[i]` is 0. Otherwise `eg_ready[i]` follows `tx_ready[i]` and `tx_valid[i]` follows `eg_valid[i]`.
- R9: `fab_rx_valid` always equals `rx_valid` and `rx_ready` always equals `fab_rx_ready`, whether or not the port is discarding.
- R10: A 0-to-1 change of `link_up[i]`, sampled at the clock, clears `discard[i]` at the next edge and blocks any expiry in that cycle.
- R11: Each port's count, error, notification, flush and discard state is independent of the other three ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global enable for dead-link timing |
| cfg_thresh | input | THRESH_W | Expiry threshold in ticks (0 treated as 1) |
| lane_sync | input | NUM_PORTS | Per-port lane synchronization status |
| link_up | input | NUM_PORTS | Per-port link trained status; a rising edge ends discard |
| notify_en | input | NUM_PORTS | Per-port error notification enable |
| err_clr | input | NUM_PORTS | Write-one-to-clear strobes for the error bits |
| port_err | output | NUM_PORTS | Sticky per-port error status |
| notify_req | output | NUM_PORTS | One-cycle notification requests |
| discard | output | NUM_PORTS | Port is in discard state |
| txbuf_flush | output | NUM_PORTS | One-cycle transmit buffer flush command |
| eg_valid | input | NUM_PORTS | Fabric offers an egress packet |
| eg_ready | output | NUM_PORTS | Egress packet accepted from the fabric |
| tx_valid | output | NUM_PORTS | Egress packet forwarded to the transmitter |
| tx_ready | input | NUM_PORTS | Transmitter can take a packet |
| rx_valid | input | NUM_PORTS | Packet received from the link partner |
| rx_ready | output | NUM_PORTS | Received packet taken by the fabric |
| fab_rx_valid | output | NUM_PORTS | Received packet offered to the fabric |
| fab_rx_ready | input | NUM_PORTS | Fabric can take a received packet |

## Verification
Two cases are hard to reach from the ports. One is a port that regains lane sync for a single cycle just short of its threshold and then loses it again. The other is an expiry that lands in the same cycle as an error clear or a link re-training edge. A deliberately short prescaler and a four-bit threshold keep each expiry within a few dozen cycles. That makes it practical to sweep every threshold value in turn, alternating the notification enable. A long phase follows in which lane sync, link training, clear strobes and small thresholds toggle pseudo-randomly on all four ports, so these coincidences occur many times. A cycle-by-cycle arithmetic model checks every output along the way.

// File: rtl/dlg_pkg.sv
package dlg_pkg;

    localparam int GROUP_PORTS = 4;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_LOST = 2'd1,
        PH_DEAD = 2'd2
    } link_phase_e;

    typedef struct packed {
        logic err;
        logic dead;
        logic notify;
        logic flush;
    } port_evt_t;

    // True when one more tick brings the count to the effective threshold.
    function automatic logic limit_reached(input int unsigned count,
                                           input int unsigned thresh);
        int unsigned eff;
        eff = (thresh == 0) ? 1 : thresh;
        return (count + 1) >= eff;
    endfunction

endpackage

// File: rtl/dlg_prescaler.sv
module dlg_prescaler #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst)              phase <= '0;
                else if (phase == LAST) phase <= '0;
                else                  phase <= phase + 1'b1;
            end

            assign tick = (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/dlg_port_timer.sv
module dlg_port_timer
    import dlg_pkg::*;
#(
    parameter int THRESH_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                enable,
    input  logic [THRESH_W-1:0] thresh,
    input  logic                lane_sync,
    input  logic                link_up,
    input  logic                notify_en,
    input  logic                err_clr,
    output port_evt_t           evt
);
    link_phase_e         phase_q, phase_d;
    logic [THRESH_W-1:0] count_q;
    logic                link_up_q;
    logic                err_q;
    logic                notify_q;
    logic                flush_q;
    logic                reinit;
    logic                counting;
    logic                expire;

    always_comb begin
        reinit   = link_up & ~link_up_q;
        counting = enable & ~lane_sync & (phase_q != PH_DEAD) & ~reinit;
        expire   = counting & tick &
                   limit_reached(32'(count_q), 32'(thresh));
    end

    always_comb begin
        if (reinit)                  phase_d = PH_SYNC;
        else if (phase_q == PH_DEAD) phase_d = PH_DEAD;
        else if (expire)             phase_d = PH_DEAD;
        else if (counting)           phase_d = PH_LOST;
        else                         phase_d = PH_SYNC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_SYNC;
            count_q   <= '0;
            link_up_q <= 1'b0;
            err_q     <= 1'b0;
            notify_q  <= 1'b0;
            flush_q   <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            link_up_q <= link_up;
            if (!counting || expire) count_q <= '0;
            else if (tick)           count_q <= count_q + 1'b1;
            err_q    <= expire | (err_q & ~err_clr);
            notify_q <= expire & ~err_q & notify_en;
            flush_q  <= expire;
        end
    end

    always_comb begin
        evt.err    = err_q;
        evt.dead   = (phase_q == PH_DEAD);
        evt.notify = notify_q;
        evt.flush  = flush_q;
    end
endmodule

// File: rtl/dlg_traffic_gate.sv
module dlg_traffic_gate #(
    parameter int NUM_PORTS = 4
) (
    input  logic [NUM_PORTS-1:0] discard,
    input  logic [NUM_PORTS-1:0] eg_valid,
    output logic [NUM_PORTS-1:0] eg_ready,
    output logic [NUM_PORTS-1:0] tx_valid,
    input  logic [NUM_PORTS-1:0] tx_ready,
    input  logic [NUM_PORTS-1:0] rx_valid,
    output logic [NUM_PORTS-1:0] rx_ready,
    output logic [NUM_PORTS-1:0] fab_rx_valid,
    input  logic [NUM_PORTS-1:0] fab_rx_ready
);
    // Egress is sunk while discarding; ingress is never touched.
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            tx_valid[i] = eg_valid[i] & ~discard[i];
            eg_ready[i] = discard[i] ? 1'b1 : tx_ready[i];
        end
        fab_rx_valid = rx_valid;
        rx_ready     = fab_rx_ready;
    end
endmodule

// File: rtl/dlink_guard.sv
module dlink_guard
    import dlg_pkg::*;
#(
    parameter int NUM_PORTS = GROUP_PORTS,
    parameter int THRESH_W  = 8,
    parameter int PRESCALE  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_enable,
    input  logic [THRESH_W-1:0]  cfg_thresh,
    input  logic [NUM_PORTS-1:0] lane_sync,
    input  logic [NUM_PORTS-1:0] link_up,
    input  logic [NUM_PORTS-1:0] notify_en,
    input  logic [NUM_PORTS-1:0] err_clr,
    output logic [NUM_PORTS-1:0] port_err,
    output logic [NUM_PORTS-1:0] notify_req,
    output logic [NUM_PORTS-1:0] discard,
    output logic [NUM_PORTS-1:0] txbuf_flush,
    input  logic [NUM_PORTS-1:0] eg_valid,
    output logic [NUM_PORTS-1:0] eg_ready,
    output logic [NUM_PORTS-1:0] tx_valid,
    input  logic [NUM_PORTS-1:0] tx_ready,
    input  logic [NUM_PORTS-1:0] rx_valid,
    output logic [NUM_PORTS-1:0] rx_ready,
    output logic [NUM_PORTS-1:0] fab_rx_valid,
    input  logic [NUM_PORTS-1:0] fab_rx_ready
);
    logic      tick;
    port_evt_t evt [NUM_PORTS];

    dlg_prescaler #(.PRESCALE(PRESCALE)) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            dlg_port_timer #(.THRESH_W(THRESH_W)) u_timer (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .enable    (cfg_enable),
                .thresh    (cfg_thresh),
                .lane_sync (lane_sync[p]),
                .link_up   (link_up[p]),
                .notify_en (notify_en[p]),
                .err_clr   (err_clr[p]),
                .evt       (evt[p])
            );
            assign port_err[p]    = evt[p].err;
            assign discard[p]     = evt[p].dead;
            assign notify_req[p]  = evt[p].notify;
            assign txbuf_flush[p] = evt[p].flush;
        end
    endgenerate

    dlg_traffic_gate #(.NUM_PORTS(NUM_PORTS)) u_gate (
        .discard      (discard),
        .eg_valid     (eg_valid),
        .eg_ready     (eg_ready),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .fab_rx_valid (fab_rx_valid),
        .fab_rx_ready (fab_rx_ready)
    );
endmodule

// File: rtl/dlink_guard_chk.sv
module dlink_guard_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_enable,
    input logic [NUM_PORTS-1:0] lane_sync,
    input logic [NUM_PORTS-1:0] notify_en,
    input logic [NUM_PORTS-1:0] err_clr,
    input logic [NUM_PORTS-1:0] port_err,
    input logic [NUM_PORTS-1:0] notify_req,
    input logic [NUM_PORTS-1:0] discard,
    input logic [NUM_PORTS-1:0] txbuf_flush
);
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
            AST_EXPIRY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
                $rose(discard[p]) |-> $past(cfg_enable) && !$past(lane_sync[p])); // R2
            AST_EXPIRY_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
                $rose(discard[p]) |-> port_err[p]); // R3
            AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
                port_err[p] && !err_clr[p] |=> port_err[p]); // R5
            AST_NOTIFY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
                notify_req[p] |-> $rose(port_err[p]) && $past(notify_en[p])); // R6
            AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (rst)
                notify_req[p] |=> !notify_req[p]); // R6
            AST_FLUSH_WITH_DISCARD: assert property (@(posedge clk) disable iff (rst)
                $rose(discard[p]) |-> txbuf_flush[p]); // R7
            AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
                txbuf_flush[p] |=> !txbuf_flush[p]); // R7
        end
    endgenerate
endmodule

bind dlink_guard dlink_guard_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_enable  (cfg_enable),
    .lane_sync   (lane_sync),
    .notify_en   (notify_en),
    .err_clr     (err_clr),
    .port_err    (port_err),
    .notify_req  (notify_req),
    .discard     (discard),
    .txbuf_flush (txbuf_flush)
);

// File: tb/dlink_guard_test.sv
module dlink_guard_test;
    localparam int NP = 4;
    localparam int TW = 4;
    localparam int PS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          cfg_enable = 1'b1;
    logic [TW-1:0] cfg_thresh = '0;
    logic [NP-1:0] lane_sync = '1, link_up = '1, notify_en = '0, err_clr = '0;
    logic [NP-1:0] eg_valid = '0, tx_ready = '0, rx_valid = '0, fab_rx_ready = '0;
    logic [NP-1:0] port_err, notify_req, discard, txbuf_flush;
    logic [NP-1:0] eg_ready, tx_valid, rx_ready, fab_rx_valid;

    dlink_guard #(.NUM_PORTS(NP), .THRESH_W(TW), .PRESCALE(PS)) uut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_thresh(cfg_thresh),
        .lane_sync(lane_sync), .link_up(link_up), .notify_en(notify_en),
        .err_clr(err_clr), .port_err(port_err), .notify_req(notify_req),
        .discard(discard), .txbuf_flush(txbuf_flush), .eg_valid(eg_valid),
        .eg_ready(eg_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .fab_rx_valid(fab_rx_valid),
        .fab_rx_ready(fab_rx_ready)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Arithmetic reference model of the requirements.
    int            m_pre;
    logic [TW-1:0] m_cnt [NP];
    logic [NP-1:0] m_dead, m_err, m_ntf, m_fl, m_luq;

    always @(posedge clk) begin
        bit tk, rein, exp_now;
        int thr;
        if (rst) begin
            m_pre <= 0; m_dead <= '0; m_err <= '0; m_ntf <= '0; m_fl <= '0; m_luq <= '0;
            for (int i = 0; i < NP; i++) m_cnt[i] <= '0;
        end else begin
            tk  = (m_pre == PS - 1);
            m_pre <= tk ? 0 : m_pre + 1;
            thr = (cfg_thresh == 0) ? 1 : int'(cfg_thresh);
            for (int i = 0; i < NP; i++) begin
                rein    = link_up[i] & ~m_luq[i];
                exp_now = cfg_enable & ~lane_sync[i] & ~m_dead[i] & ~rein & tk &
                          (int'(m_cnt[i]) + 1 >= thr);
                m_luq[i] <= link_up[i];
                m_dead[i] <= rein ? 1'b0 : (m_dead[i] | exp_now);
                m_err[i]  <= exp_now | (m_err[i] & ~err_clr[i]);
                m_ntf[i]  <= exp_now & ~m_err[i] & notify_en[i];
                m_fl[i]   <= exp_now;
                if (!cfg_enable || lane_sync[i] || m_dead[i] || rein || exp_now)
                    m_cnt[i] <= '0;
                else if (tk)
                    m_cnt[i] <= m_cnt[i] + 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 discard",     32'(discard),     32'(m_dead));
            chk("R5 port_err",    32'(port_err),    32'(m_err));
            chk("R6 notify_req",  32'(notify_req),  32'(m_ntf));
            chk("R7 txbuf_flush", 32'(txbuf_flush), 32'(m_fl));
            chk("R8 tx_valid",    32'(tx_valid),    32'(eg_valid & ~discard));
            chk("R8 eg_ready",    32'(eg_ready),    32'(discard | tx_ready));
            chk("R9 fab_rx_valid", 32'(fab_rx_valid), 32'(rx_valid));
            chk("R9 rx_ready",    32'(rx_ready),    32'(fab_rx_ready));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic retrain(input logic [NP-1:0] m);
        lane_sync = '1; err_clr = '1; link_up = link_up & ~m;
        cyc(1);
        err_clr = '0; link_up = '1;
        cyc(2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Handshake traffic on every cycle.
    initial begin
        forever begin
            @(posedge clk); #1;
            eg_valid = NP'($urandom); tx_ready = NP'($urandom);
            rx_valid = NP'($urandom); fab_rx_ready = NP'($urandom);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        #1;
        // R1: reset values
        chk("R1 reset outputs", 32'({port_err, notify_req, discard, txbuf_flush}), 32'h0);

        // R3/R6: sweep every threshold on port 0, notifications alternating
        for (int t = 0; t < (1 << TW); t++) begin
            cfg_thresh = TW'(t);
            notify_en  = {NP{t[0]}};
            lane_sync  = 4'b1110;
            cyc(((t == 0 ? 1 : t) + 1) * PS + 2);
            chk("R11 only port 0 dead", 32'(discard), 32'h1);
            retrain(4'b0001);
            chk("R10 discard cleared by retrain", 32'(discard), 32'h0);
        end

        // R4: brief sync recovery restarts the count
        cfg_thresh = 4'd3;
        lane_sync  = 4'b1101;
        cyc(2 * PS);
        lane_sync = '1;
        cyc(1);
        lane_sync = 4'b1101;
        cyc(2 * PS);
        chk("R4 count restarted", 32'(discard), 32'h0);
        cyc(2 * PS);
        chk("R4 later expiry", 32'(discard), 32'h2);
        retrain(4'b0010);

        // R2: disabled timer never expires
        cfg_enable = 1'b0;
        lane_sync  = '0;
        cyc(20 * PS);
        chk("R2 no expiry when disabled", 32'(discard | port_err), 32'h0);
        cfg_enable = 1'b1;
        cyc(1);
        chk("R2 count restarts after enable", 32'(discard), 32'h0);
        cyc(5 * PS);
        chk("R11 all ports dead", 32'(discard), 32'hF);
        retrain('1);

        // Random phase: coincidences of clear, retrain, sync loss, enable
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < NP; i++) begin
                if ($urandom_range(5) == 0) lane_sync[i] = ~lane_sync[i];
                link_up[i] = ($urandom_range(19) != 0);
                err_clr[i] = ($urandom_range(7) == 0);
            end
            notify_en  = NP'($urandom);
            cfg_thresh = TW'($urandom_range(3));
            cfg_enable = ($urandom_range(9) != 0);
            cyc(1);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule